// File: doc/BRIEF.md
# Bridge Control Register File

This block is the memory-mapped control word bank of a host bridge. It holds twenty-eight 32-bit words at byte offsets 0x00 through 0x6C: power-on and general configuration, device and memory setup, address-map control, GPIO data and enables, interrupt edge, steering and polarity words, four mailboxes, cache control and tag words, timing, CPU and memory-size settings. Software reaches it over a simple register bus with a byte address, a write strobe, write data and a combinational read-data return. Only whole-word accesses are accepted.

Interrupt enables cannot be written directly. One alias sets enable bits and another clears them. The live enable word, the edge-mode word and the polarity word are driven out as ports for the interrupt logic next to this block. A write that takes one bit of the general-config word from 0 to 1 raises a single-cycle system reset request.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset, the bank reads 0x00000C40 at 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C and at 0x20, 0x00000008 at 0x68 and 0x10000000 at 0x6C. Every other offset reads zero.
- R2: A write to any offset from 0x00 to 0x6C, other than 0x30, 0x34, 0x38 and 0x3C, stores the full 32-bit value. The value reads back from the next cycle on.
- R3: A write to 0x30 stores the value there. On the same clock edge, the written 1-bits are set in the enable word at 0x38.
- R4: A write to 0x34 stores the value there. On the same clock edge, the written 1-bits are cleared in the enable word at 0x38.
- R5: Writes to 0x38 (enable word) and 0x3C (interrupt status) have no effect. The status word at 0x3C always reads zero. The enable word changes only through writes to 0x30 and 0x34.
- R6: `reset_req` is high for exactly one cycle, the cycle after a write to 0x04 whose data has bit 2 set while the stored bit 2 was 0. It is low at all other times, including a rewrite of bit 2 that is already 1.
- R7: Offsets 0x70 to 0x7F are outside the bank. Writes there are ignored and reads return zero.
- R8: An access whose address has nonzero bits [1:0] is not a whole-word access. Such a write is ignored and such a read returns zero.
- R9: `irq_enable` always equals the word at 0x38, `irq_edge` the word at 0x24 and `irq_pol` the word at 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Byte address of the access |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_enable | output | 32 | Live interrupt enable word |
| irq_edge | output | 32 | Interrupt edge/level mode word |
| irq_pol | output | 32 | Interrupt polarity word |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the assertions check three things: how the enable word responds to the set and clear aliases, that the enable word holds steady when neither alias is written, and that `reset_req` is a lone pulse following a write to 0x04 with bit 2 set. They also check that reads outside the bank return zero. The scenarios are needed for the rest: the exact reset values, full-word readback of plain registers, the blocking of misaligned writes, and the 0-to-1 condition on bit 2. The last one needs the stored bit to be cleared first and then rewritten both with a 1 and a second time with a 1.

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs #(
  parameter int AW     = 7,
  parameter int DW     = 32,
  parameter int NWORDS = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] irq_enable,
  output logic [DW-1:0] irq_edge,
  output logic [DW-1:0] irq_pol,
  output logic          reset_req
);
  localparam int IW      = AW - 2;
  localparam int GEN_IDX = 1;
  localparam int EDG_IDX = 9;
  localparam int POL_IDX = 11;
  localparam int SET_IDX = 12;
  localparam int CLR_IDX = 13;
  localparam int EN_IDX  = 14;
  localparam int ST_IDX  = 15;
  localparam int RST_BIT = 2;

  function automatic logic [DW-1:0] init_word(input int i);
    case (i)
      0:       return DW'(32'h0000_0C40);
      1:       return DW'(32'h0000_1384);
      2:       return DW'(32'h2BFF_8010);
      3:       return DW'(32'h255E_0091);
      4:       return DW'(32'h0000_6140);
      7, 8:    return DW'(32'h0000_01FF);
      26:      return DW'(32'h0000_0008);
      27:      return DW'(32'h1000_0000);
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] words [NWORDS];
  logic [IW-1:0] widx;
  logic          hit;
  logic          wr;

  assign widx = reg_addr[AW-1:2];
  assign hit  = (reg_addr[1:0] == 2'b00) && (int'(widx) < NWORDS);
  assign wr   = reg_we && hit;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    if (i == EN_IDX) begin : g_en
      always_ff @(posedge clk)
        if (!rst_n)                             words[i] <= init_word(i);
        else if (wr && widx == IW'(SET_IDX))    words[i] <= words[i] | reg_wdata;
        else if (wr && widx == IW'(CLR_IDX))    words[i] <= words[i] & ~reg_wdata;
    end else if (i == ST_IDX) begin : g_st
      always_ff @(posedge clk) words[i] <= '0;
    end else begin : g_rw
      always_ff @(posedge clk)
        if (!rst_n)                             words[i] <= init_word(i);
        else if (wr && widx == IW'(i))          words[i] <= reg_wdata;
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= wr && widx == IW'(GEN_IDX) &&
                             !words[GEN_IDX][RST_BIT] && reg_wdata[RST_BIT];

  assign reg_rdata  = hit ? words[widx] : '0;
  assign irq_enable = words[EN_IDX];
  assign irq_edge   = words[EDG_IDX];
  assign irq_pol    = words[POL_IDX];
endmodule

module bridge_ctrl_regs_chk #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] irq_enable,
  input logic          reset_req
);
  localparam logic [AW-1:0] SET_A = AW'(7'h30);
  localparam logic [AW-1:0] CLR_A = AW'(7'h34);
  localparam logic [AW-1:0] GEN_A = AW'(7'h04);
  localparam logic [AW-1:0] END_A = AW'(7'h70);

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == SET_A) |=> irq_enable == ($past(irq_enable) | $past(reg_wdata)));
  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == CLR_A) |=> irq_enable == ($past(irq_enable) & ~$past(reg_wdata)));
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == SET_A || reg_addr == CLR_A)) |=> $stable(irq_enable));
  // R6
  rr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(reg_we && reg_addr == GEN_A && reg_wdata[2]));
  // R6
  rr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R7
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= END_A) |-> reg_rdata == '0);
endmodule

bind bridge_ctrl_regs bridge_ctrl_regs_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/bridge_ctrl_regs_tb.sv
`timescale 1ns/1ps
module bridge_ctrl_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, irq_enable, irq_edge, irq_pol;
  logic        reset_req;

  int vectors = 0;
  int fails = 0;
  bit init_phase = 0;

  always #2.5 clk = ~clk;

  bridge_ctrl_regs u_dut (.*);

  logic [31:0] m [28];
  bit          exp_rr;

  function automatic logic [31:0] rst_value(input int i);
    case (i)
      0: return 32'h0000_0C40;  1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
      4: return 32'h0000_6140;  7: return 32'h0000_01FF;
      8: return 32'h0000_01FF;  26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [6:0] a);
    if (a[1:0] != 0 || a >= 7'h70) return 32'h0;
    return m[a >> 2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 28; i++) m[i] = rst_value(i);
      exp_rr = 0;
    end else begin
      exp_rr = 0;
      if (reg_we && reg_addr[1:0] == 0 && reg_addr < 7'h70) begin
        int k;
        k = reg_addr >> 2;
        if (k == 1 && !m[1][2] && reg_wdata[2]) exp_rr = 1;
        if (k == 12) begin m[12] = reg_wdata; m[14] = m[14] | reg_wdata; end
        else if (k == 13) begin m[13] = reg_wdata; m[14] = m[14] & ~reg_wdata; end
        else if (k != 14 && k != 15) m[k] = reg_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %08h expected %08h", req, $time, act, exp);
    end
  endtask

  function automatic string read_tag(input logic [6:0] a);
    if (init_phase) return "R1";
    if (a[1:0] != 0) return "R8";
    if (a >= 7'h70) return "R7";
    if (a == 7'h38 || a == 7'h3C) return "R5";
    if (a == 7'h30) return "R3";
    if (a == 7'h34) return "R4";
    return "R2";
  endfunction

  task automatic compare();
    logic [31:0] e;
    if (!rst_n) return;
    e = model_read(reg_addr);
    check(reg_rdata === e, read_tag(reg_addr), reg_rdata, e);
    check(irq_enable === m[14], "R9 enable", irq_enable, m[14]);
    check(irq_edge === m[9], "R9 edge", irq_edge, m[9]);
    check(irq_pol === m[11], "R9 pol", irq_pol, m[11]);
    check(reset_req === exp_rr, "R6", {31'b0, reset_req}, {31'b0, exp_rr});
  endtask

  task automatic step(input bit we, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    reg_we = we; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    step(1, a, d);
  endtask

  task automatic rd(input logic [6:0] a);
    step(0, a, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    init_phase = 1;
    // R1: reset value sweep over the whole word space
    for (int a = 0; a < 128; a += 4) rd(7'(a));
    rd(7'h00);
    init_phase = 0;
    // R2: plain registers, two data patterns, with R5/R7 offsets included
    for (int a = 0; a < 128; a += 4) wr(7'(a), 32'hA5A5_0000 | 32'(a));
    for (int a = 0; a < 128; a += 4) rd(7'(a));
    for (int a = 0; a < 128; a += 4) wr(7'(a), ~(32'h5A00_0000 | 32'(a)));
    for (int a = 0; a < 128; a += 4) rd(7'(a));
    // R3 / R4: set and clear aliases
    wr(7'h34, 32'hFFFF_FFFF); rd(7'h38);
    wr(7'h30, 32'h0000_00F0); rd(7'h38);
    wr(7'h30, 32'h8000_0001); rd(7'h38); rd(7'h30);
    wr(7'h34, 32'h0000_0030); rd(7'h38); rd(7'h34);
    wr(7'h30, 32'h0); wr(7'h34, 32'h0); rd(7'h38);
    // R5: direct writes to enable and status have no effect
    wr(7'h38, 32'hFFFF_FFFF); rd(7'h38);
    wr(7'h38, 32'h0); rd(7'h38);
    wr(7'h3C, 32'hDEAD_BEEF); rd(7'h3C);
    // R8: misaligned accesses
    wr(7'h09, 32'h1111_1111); wr(7'h0A, 32'h2222_2222); wr(7'h0B, 32'h3333_3333);
    rd(7'h08); rd(7'h09); rd(7'h0E);
    // R7: out of bank
    wr(7'h70, 32'hFFFF_FFFF); wr(7'h7C, 32'h1234_5678); rd(7'h70); rd(7'h7C); rd(7'h00);
    // R6: reset request on 0-to-1 of bit 2 only
    wr(7'h04, 32'h0000_1380); rd(7'h04);
    wr(7'h04, 32'h0000_1384); rd(7'h04); rd(7'h04);
    wr(7'h04, 32'h0000_1384); rd(7'h04);
    wr(7'h04, 32'h0); wr(7'h04, 32'h4); wr(7'h04, 32'h4); rd(7'h04);
    wr(7'h05, 32'h0); rd(7'h04);
    // R9: edge and polarity words
    wr(7'h24, 32'h0F0F_0F0F); wr(7'h2C, 32'hF0F0_F0F0); rd(7'h24); rd(7'h2C);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [6:0] a;
      a = 7'($urandom_range(0, 127));
      if (($urandom & 3) == 0) a = 7'h04;
      else if (($urandom & 3) == 1) a = (($urandom & 1) != 0) ? 7'h30 : 7'h34;
      step(($urandom & 1) != 0, a, $urandom);
    end
    rd(7'h38);
    rd(7'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule